// File: doc/BRIEF.md
# Extended-Condition Block Execution Counter

This block lets an instruction set keep only a 2-bit condition field in each instruction while still offering every C/Z flag condition. A dedicated block instruction carries a 4-bit extended condition code and a length. When it issues, the condition is evaluated once against the current C and Z flags and stored as one bit, and a counter is loaded with the length. Each following issued instruction decrements the counter. While the counter is non-zero, an issued instruction executes only when the stored bit is true and its own short condition also holds. Otherwise it is cancelled.

While a block is active the block holds off interrupts. A taken branch ends the block at once. Lengths of zero leave the block idle. A block instruction issued inside an active block starts a fresh block. The execute-enable output is combinational from the issue strobe and the registered block state. The interrupt-inhibit output is registered.

Top module: `xcb_top`

## Requirements
- R1: After reset no block is active, int_inhibit is 0, and an instruction issued with short code 00 executes.
- R2: The 2-bit short code of a non-block instruction selects: 00 always, 01 if Z=1, 10 if C=1, 11 if C=0. Outside a block, exec_en equals issue AND that test on the flags present in the same cycle.
- R3: A block instruction's 4-bit code is a truth table indexed by {C,Z}: bit (2*C+Z) is the result. So 1110 is below-or-equal (C OR Z), 1100 is if C, 0000 is never and 1111 is always. Inside an active block, an issued instruction executes only if the stored result is 1 and its short code holds.
- R4: Every issued non-block instruction inside a block decrements the count, whether it executes or not. Cycles without issue do not decrement it. After exactly len issued instructions the block ends, and later instructions follow R2 again. This holds up to the largest length, 2^LEN_W-1.
- R5: int_inhibit goes high in the cycle after a block instruction with non-zero length issues. It stays high while the count is non-zero.
- R6: A block instruction with length 0 leaves the block inactive and int_inhibit low.
- R7: branch_taken ends an active block from the next cycle, unless a block instruction issues in the same cycle, in which case the load wins.
- R8: A block instruction issued inside an active block reloads both the count and the stored condition.
- R9: Flag changes inside a block do not change the stored condition result.
- R10: exec_en is 0 in any cycle where issue is 0.
- R11: An issued block instruction itself always has exec_en = 1, and it does not decrement the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction issues this cycle |
| blk_valid | input | 1 | The issuing instruction is a block instruction |
| blk_code | input | 4 | Extended condition truth table of the block instruction |
| blk_len | input | LEN_W | Number of following instructions covered |
| short_cc | input | 2 | Per-instruction 2-bit condition code |
| flag_c | input | 1 | Current C flag |
| flag_z | input | 1 | Current Z flag |
| branch_taken | input | 1 | A branch was taken this cycle |
| exec_en | output | 1 | The issued instruction executes |
| int_inhibit | output | 1 | Interrupts must be held off |

## Verification
The bench builds the block with LEN_W = 4. With that width the full-length block of 15 instructions can be counted through in a short run, and the zero-length corner lies one step away from a single-instruction block. That width also keeps back-to-back reloads, branch cancellation partway through a block, and idle gaps inside a block within a few dozen cycles. Each of these is exercised with the condition both true and false.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
  // Short per-instruction condition codes
  typedef enum logic [1:0] {
    SC_ALWAYS = 2'b00,
    SC_IF_Z   = 2'b01,
    SC_IF_C   = 2'b10,
    SC_IF_NC  = 2'b11
  } short_cc_e;

  // Extended condition: truth table indexed by {C,Z}
  function automatic logic ext_cond_hit(input logic [3:0] code, input logic c, input logic z);
    return code[{c, z}];
  endfunction

  function automatic logic short_cond_hit(input logic [1:0] cc, input logic c, input logic z);
    logic r;
    case (short_cc_e'(cc))
      SC_ALWAYS: r = 1'b1;
      SC_IF_Z:   r = z;
      SC_IF_C:   r = c;
      default:   r = ~c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xcb_cond_eval.sv
module xcb_cond_eval
  import xcb_pkg::*;
(
  input  logic [3:0] blk_code,
  input  logic [1:0] short_cc,
  input  logic       flag_c,
  input  logic       flag_z,
  output logic       blk_hit,
  output logic       short_hit
);
  always_comb begin
    blk_hit   = ext_cond_hit(blk_code, flag_c, flag_z);
    short_hit = short_cond_hit(short_cc, flag_c, flag_z);
  end
endmodule

// File: rtl/xcb_block_ctr.sv
module xcb_block_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_hit,
  input  logic             step,
  input  logic             clear,
  output logic             active,
  output logic             hit_q,
  output logic [LEN_W-1:0] count
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_len;
      hit_q <= load_hit;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign active = (cnt_q != '0);
  assign count  = cnt_q;

  // R4: a step inside a block lowers the count by exactly one
  p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && !clear) |=> (count == $past(count) - ONE));

  // R9: the stored result only changes on a load
  p_hit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> $stable(hit_q));
endmodule

// File: rtl/xcb_top.sv
module xcb_top #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             blk_valid,
  input  logic [3:0]       blk_code,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [1:0]       short_cc,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             branch_taken,
  output logic             exec_en,
  output logic             int_inhibit
);
  // Named internal events
  logic             blk_issue;
  logic             plain_issue;
  logic             blk_hit;
  logic             short_hit;
  logic             active;
  logic             hit_q;
  logic [LEN_W-1:0] count;
  logic             gate_ok;

  assign blk_issue   = issue && blk_valid;
  assign plain_issue = issue && !blk_valid;

  xcb_cond_eval u_eval (
    .blk_code (blk_code),
    .short_cc (short_cc),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .blk_hit  (blk_hit),
    .short_hit(short_hit)
  );

  xcb_block_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (blk_issue),
    .load_len(blk_len),
    .load_hit(blk_hit),
    .step    (plain_issue),
    .clear   (branch_taken),
    .active  (active),
    .hit_q   (hit_q),
    .count   (count)
  );

  assign gate_ok     = !active || hit_q;
  assign exec_en     = blk_issue || (plain_issue && short_hit && gate_ok);
  assign int_inhibit = active;

  // R5: non-zero length raises the inhibit next cycle
  p_inhibit_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_issue && blk_len != '0) |=> int_inhibit);

  // R6: zero length leaves the block idle
  p_zero_len_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_issue && blk_len == '0) |=> !int_inhibit);

  // R7: branch cancels the block
  p_branch_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_taken && !blk_issue) |=> !int_inhibit);

  // R10: nothing executes without an issue
  p_no_issue_no_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue) |-> !exec_en);

  // R3: a false stored result cancels plain instructions in a block
  p_false_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_inhibit && !hit_q && plain_issue) |-> !exec_en);
endmodule

// File: tb/xcb_top_tb.sv
module xcb_top_tb;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue = 1'b0;
  logic             blk_valid = 1'b0;
  logic [3:0]       blk_code = '0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [1:0]       short_cc = '0;
  logic             flag_c = 1'b0;
  logic             flag_z = 1'b0;
  logic             branch_taken = 1'b0;
  logic             exec_en;
  logic             int_inhibit;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  xcb_top #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .blk_valid(blk_valid),
    .blk_code(blk_code), .blk_len(blk_len), .short_cc(short_cc),
    .flag_c(flag_c), .flag_z(flag_z), .branch_taken(branch_taken),
    .exec_en(exec_en), .int_inhibit(int_inhibit)
  );

  // Bench's own restatement of the short code table
  function automatic logic short_ref(input logic [1:0] cc, input logic c, input logic z);
    if (cc == 2'b00) return 1'b1;
    if (cc == 2'b01) return z == 1'b1;
    if (cc == 2'b10) return c == 1'b1;
    return c == 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive one cycle at negedge, sample mid-low-phase, then pass the posedge.
  // exp_x / exp_i: -1 skip, else expected exec_en / int_inhibit (state before edge)
  task automatic cyc(input string req, input logic iss, input logic blk,
                     input logic [3:0] code, input int len, input logic [1:0] cc,
                     input logic c, input logic z, input logic br,
                     input int exp_x, input int exp_i);
    @(negedge clk);
    issue = iss; blk_valid = blk; blk_code = code; blk_len = LEN_W'(len);
    short_cc = cc; flag_c = c; flag_z = z; branch_taken = br;
    #5;
    if (exp_x >= 0) chk(req, "exec_en", exec_en, exp_x[0]);
    if (exp_i >= 0) chk(req, "int_inhibit", int_inhibit, exp_i[0]);
    @(posedge clk);
  endtask

  task automatic plain(input string req, input logic [1:0] cc, input logic c,
                       input logic z, input int exp_x, input int exp_i);
    cyc(req, 1'b1, 1'b0, 4'h0, 0, cc, c, z, 1'b0, exp_x, exp_i);
  endtask

  task automatic blk(input string req, input logic [3:0] code, input int len,
                     input logic c, input logic z, input int exp_i);
    cyc(req, 1'b1, 1'b1, code, len, 2'b00, c, z, 1'b0, 1, exp_i);  // R11
  endtask

  task automatic idle(input string req, input int exp_i);
    cyc(req, 1'b0, 1'b0, 4'h0, 0, 2'b00, 1'b0, 1'b0, 1'b0, 0, exp_i);
  endtask

  task automatic t_reset;
    idle("R1", 0);
    plain("R1", 2'b00, 1'b0, 1'b0, 1, 0);
    idle("R10", 0);
  endtask

  task automatic t_short;
    for (int cc = 0; cc < 4; cc++)
      for (int f = 0; f < 4; f++)
        plain("R2", 2'(cc), f[1], f[0], int'(short_ref(2'(cc), f[1], f[0])), 0);
  endtask

  task automatic t_block_be;
    // below-or-equal = C OR Z; Z=1 gives true
    blk("R3", 4'b1110, 3, 1'b0, 1'b1, 0);
    plain("R3", 2'b00, 1'b0, 1'b0, 1, 1);
    plain("R3", 2'b01, 1'b0, 1'b1, 1, 1);
    plain("R3", 2'b01, 1'b0, 1'b0, 0, 1);   // short code still applies
    plain("R4", 2'b00, 1'b0, 1'b0, 1, 0);
    // false: C=0,Z=0
    blk("R3", 4'b1110, 2, 1'b0, 1'b0, 0);
    plain("R3", 2'b00, 1'b0, 1'b0, 0, 1);
    plain("R3", 2'b00, 1'b1, 1'b1, 0, 1);
    plain("R4", 2'b00, 1'b0, 1'b0, 1, 0);
  endtask

  task automatic t_never_always;
    blk("R3", 4'b0000, 2, 1'b1, 1'b1, 0);
    plain("R3", 2'b00, 1'b1, 1'b1, 0, 1);
    plain("R3", 2'b00, 1'b1, 1'b1, 0, 1);
    plain("R4", 2'b00, 1'b1, 1'b1, 1, 0);
    blk("R3", 4'b1111, 1, 1'b0, 1'b0, 0);
    plain("R3", 2'b00, 1'b0, 1'b0, 1, 1);
    idle("R5", 0);
  endtask

  task automatic t_zero;
    blk("R6", 4'b0000, 0, 1'b0, 1'b0, 0);
    plain("R6", 2'b00, 1'b0, 1'b0, 1, 0);
    idle("R6", 0);
  endtask

  task automatic t_branch;
    blk("R7", 4'b0000, 5, 1'b0, 1'b0, 0);
    plain("R7", 2'b00, 1'b0, 1'b0, 0, 1);
    cyc("R7", 1'b0, 1'b0, 4'h0, 0, 2'b00, 1'b0, 1'b0, 1'b1, 0, 1);
    plain("R7", 2'b00, 1'b0, 1'b0, 1, 0);
    // branch together with a block instruction: load wins
    blk("R7", 4'b0000, 3, 1'b0, 1'b0, 0);
    cyc("R7", 1'b1, 1'b1, 4'b1111, 2, 2'b00, 1'b0, 1'b0, 1'b1, 1, 1);
    plain("R7", 2'b00, 1'b0, 1'b0, 1, 1);
    plain("R7", 2'b00, 1'b0, 1'b0, 1, 1);
    idle("R7", 0);
  endtask

  task automatic t_reload;
    blk("R8", 4'b0000, 4, 1'b0, 1'b0, 0);
    plain("R8", 2'b00, 1'b0, 1'b0, 0, 1);
    blk("R11", 4'b1100, 2, 1'b1, 1'b0, 1);   // if C, C=1 -> true
    plain("R8", 2'b00, 1'b0, 1'b0, 1, 1);
    plain("R8", 2'b00, 1'b0, 1'b0, 1, 1);
    plain("R8", 2'b10, 1'b0, 1'b0, 0, 0);    // block over, short if C with C=0
  endtask

  task automatic t_flags;
    blk("R9", 4'b1100, 3, 1'b1, 1'b0, 0);
    plain("R9", 2'b00, 1'b0, 1'b0, 1, 1);
    plain("R9", 2'b00, 1'b0, 1'b1, 1, 1);
    blk("R9", 4'b1100, 2, 1'b0, 1'b1, 1);
    plain("R9", 2'b00, 1'b1, 1'b1, 0, 1);
    plain("R9", 2'b00, 1'b1, 1'b0, 0, 1);
    idle("R9", 0);
  endtask

  task automatic t_gaps;
    blk("R4", 4'b0000, 2, 1'b0, 1'b0, 0);
    idle("R4", 1);
    idle("R4", 1);
    idle("R10", 1);
    plain("R4", 2'b00, 1'b0, 1'b0, 0, 1);
    idle("R4", 1);
    plain("R4", 2'b00, 1'b0, 1'b0, 0, 1);
    plain("R4", 2'b00, 1'b0, 1'b0, 1, 0);
  endtask

  task automatic t_maxlen;
    blk("R4", 4'b0000, 15, 1'b0, 1'b0, 0);
    for (int i = 0; i < 15; i++) plain("R4", 2'b00, 1'b0, 1'b0, 0, 1);
    plain("R4", 2'b00, 1'b0, 1'b0, 1, 0);
  endtask

  initial begin : watchdog
    #1000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short();
    t_block_be();
    t_never_always();
    t_zero();
    t_branch();
    t_reload();
    t_flags();
    t_gaps();
    t_maxlen();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule